// File: doc/BRIEF.md
# Periodic Wake-up Timer

A programmable timer that raises a sticky interrupt flag once every 2 × (rate + 1) cycles of a selected time base. The time base is either every bus clock cycle or the pulses of a slower auxiliary source. The auxiliary source arrives as a single-cycle strobe, `aux_tick`, that is synchronous to the bus clock. Software programs the timer over a byte-wide register port. The port has write and read strobes, a two-bit address and a registered read-data path. Software sets a run bit to start the timer and acknowledges each timeout by writing one to the flag.

The 16-bit rate value is split into a high byte at the lower address and a low byte at the next address. While the timer runs, both rate bytes are frozen. When the auxiliary source is selected, the counter waits for a two-stage gate-release synchronizer before it counts. This adds two auxiliary ticks of latency to the first period only.

The controller has three states. `ST_IDLE` holds the counter at its reload value. `ST_GATE` waits for the synchronized enable. `ST_COUNT` decrements the counter on each source tick. The transitions are:
- *start_bus*: from IDLE to COUNT, when run is set and the bus clock is selected.
- *start_aux*: from IDLE to GATE, when run is set and the auxiliary source is selected.
- *gate_open*: from GATE to COUNT, once the synchronizer output is high.
- *src_switch*: from GATE to COUNT, when the bus clock gets selected while waiting.
- *stop*: from GATE or COUNT to IDLE, whenever run is clear.

Top module: `periodic_wake_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is low.
- R2: The register addresses are as follows. Address 0 is control: bit 0 = run, bit 1 = source (1 = bus clock, 0 = auxiliary), bit 2 = interrupt enable, and the other bits read 0. Address 1 is status: bit 0 = flag. Address 2 is rate[15:8]. Address 3 is rate[7:0]. Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`.
- R3: A write to address 2 or 3 while run is 1 leaves the rate unchanged. The same write with run at 0 takes effect.
- R4: Once counting, successive timeouts are exactly 2 × (rate + 1) source ticks apart.
- R5: With the bus clock selected, the first timeout occurs on the (2 × (rate + 1) + 1)-th clock edge after the edge that wrote run = 1.
- R6: With the auxiliary source selected, the first timeout occurs on the (2 × (rate + 1) + 2)-th `aux_tick` pulse after the enabling write. `aux_tick` pulses must be separated by at least one idle cycle.
- R7: Each timeout sets the flag, and the flag stays set until software writes 1 to status bit 0. Writing 0 to that bit has no effect. A timeout in the same cycle as a clear leaves the flag set.
- R8: `irq_o` equals the flag ANDed with the interrupt-enable bit.
- R9: Clearing run stops counting at once, and no timeout occurs while run is 0. The next enable starts a full first period as in R5 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| aux_tick | input | 1 | One-cycle pulse per auxiliary-clock period |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps rates 0 through 6 plus two larger values under both sources. For each, it measures the first period and two later periods in source ticks. A counter loaded with 2 × rate instead of 2 × rate + 1 would show every period one tick short. A wrong gate-release path would move the first auxiliary timeout but not the later ones. A missing write lock shows up twice: the rate reads back changed while running, and the running period changes. A stop that only freezes the counter shows up on restart, where the first timeout after re-enable comes early. The bench also checks the W1C flag against a zero write, and checks that the interrupt enable masks `irq_o` while the flag stays readable.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_COUNT = 2'd2
    } run_state_t;

    localparam int unsigned REG_CTRL    = 0;
    localparam int unsigned REG_STAT    = 1;
    localparam int unsigned REG_RATE_HI = 2;
    localparam int unsigned REG_RATE_LO = 3;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_SRC_BIT = 1;
    localparam int unsigned CTRL_IEN_BIT = 2;
    localparam int unsigned STAT_FLG_BIT = 0;

endpackage

// File: rtl/pwt_regs.sv
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int unsigned RATE_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              timeout,
    output logic              run,
    output logic              src_bus,
    output logic              irq_en,
    output logic [RATE_W-1:0] rate,
    output logic              flag
);

    localparam int unsigned HI_W = RATE_W - 8;

    logic       wr_ctrl, wr_stat, wr_hi, wr_lo;
    logic [7:0] hi_byte;
    logic [7:0] rd_mux;

    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
        wr_stat = wr_en && (addr == ADDR_W'(REG_STAT));
        wr_hi   = wr_en && (addr == ADDR_W'(REG_RATE_HI));
        wr_lo   = wr_en && (addr == ADDR_W'(REG_RATE_LO));
    end

    always_comb begin
        hi_byte             = '0;
        hi_byte[HI_W-1:0]   = rate[RATE_W-1:8];
        rd_mux              = '0;
        if (addr == ADDR_W'(REG_CTRL)) begin
            rd_mux[CTRL_RUN_BIT] = run;
            rd_mux[CTRL_SRC_BIT] = src_bus;
            rd_mux[CTRL_IEN_BIT] = irq_en;
        end else if (addr == ADDR_W'(REG_STAT)) begin
            rd_mux[STAT_FLG_BIT] = flag;
        end else if (addr == ADDR_W'(REG_RATE_HI)) begin
            rd_mux = hi_byte;
        end else if (addr == ADDR_W'(REG_RATE_LO)) begin
            rd_mux = rate[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            src_bus <= 1'b0;
            irq_en  <= 1'b0;
            rate    <= '0;
            flag    <= 1'b0;
            rdata   <= '0;
        end else begin
            if (wr_ctrl) begin
                run     <= wdata[CTRL_RUN_BIT];
                src_bus <= wdata[CTRL_SRC_BIT];
                irq_en  <= wdata[CTRL_IEN_BIT];
            end
            if (wr_hi && !run) rate[RATE_W-1:8] <= wdata[HI_W-1:0];
            if (wr_lo && !run) rate[7:0]        <= wdata;
            if (timeout)
                flag <= 1'b1;
            else if (wr_stat && wdata[STAT_FLG_BIT])
                flag <= 1'b0;
            if (rd_en) rdata <= rd_mux;
        end
    end

    // R3: the rate cannot move in a cycle that started with run set
    a_r3_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(rate));

    // R7: the flag only falls after a write of one to the status bit
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag) && !($past(wr_stat) && $past(wdata[STAT_FLG_BIT]))) |-> flag);

endmodule

// File: rtl/pwt_gate_sync.sv
module pwt_gate_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic aux_tick,
    output logic gate_open
);

    logic stage1;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            stage1    <= 1'b0;
            gate_open <= 1'b0;
        end else if (aux_tick) begin
            stage1    <= 1'b1;
            gate_open <= stage1;
        end
    end

    // R6: the gate only opens on an auxiliary tick
    a_r6_gate_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(aux_tick));

endmodule

// File: rtl/pwt_core.sv
module pwt_core
    import pwt_pkg::*;
#(
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              src_bus,
    input  logic              aux_tick,
    input  logic              gate_open,
    input  logic [RATE_W-1:0] rate,
    output logic              timeout
);

    localparam int unsigned CNT_W = RATE_W + 1;

    run_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic             src_tick;
    logic             counting;

    assign reload = {rate, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        src_tick  = src_bus ? 1'b1 : aux_tick;
        counting  = 1'b0;
        timeout   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) state_nxt = src_bus ? ST_COUNT : ST_GATE;
            end
            ST_GATE: begin
                if (!run)                      state_nxt = ST_IDLE;
                else if (src_bus || gate_open) state_nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run) state_nxt = ST_IDLE;
                counting = run && src_tick;
                timeout  = counting && (cnt == '0);
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state != ST_COUNT || !run) begin
            cnt <= reload;
        end else if (counting) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    // R4: while counting the counter never exceeds the reload value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt <= reload));

    // R9: clearing run returns the controller to idle on the next edge
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_IDLE));

endmodule

// File: rtl/periodic_wake_timer.sv
module periodic_wake_timer #(
    parameter int unsigned RATE_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              aux_tick,
    output logic              irq_o
);

    logic              run, src_bus, irq_en, flag, timeout, gate_open;
    logic [RATE_W-1:0] rate;

    pwt_regs #(.RATE_W(RATE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .timeout(timeout), .run(run), .src_bus(src_bus),
        .irq_en(irq_en), .rate(rate), .flag(flag)
    );

    pwt_gate_sync u_sync (
        .clk(clk), .rst_n(rst_n), .run(run),
        .aux_tick(aux_tick), .gate_open(gate_open)
    );

    pwt_core #(.RATE_W(RATE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .src_bus(src_bus),
        .aux_tick(aux_tick), .gate_open(gate_open), .rate(rate),
        .timeout(timeout)
    );

    assign irq_o = flag && irq_en;

    // R8: an interrupt needs the enable bit
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);

endmodule

// File: tb/tb_periodic_wake_timer.sv
`timescale 1ns/1ps
module tb_periodic_wake_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       aux_tick = 1'b0;
    logic       irq_o;

    int checks = 0, failures = 0;
    int ticks = 0, rise_tick = 0, aux_phase = 0;
    bit rose = 0, irq_prev = 0, src_bus_tb = 0;

    always #4 clk = ~clk;

    periodic_wake_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .aux_tick(aux_tick), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_edge();
        @(posedge clk);
        @(negedge clk);
        if (src_bus_tb || aux_tick) ticks++;
        if (irq_o && !irq_prev) begin
            rose = 1;
            rise_tick = ticks;
        end
        irq_prev = irq_o;
        aux_phase = (aux_phase + 1) % 3;
        aux_tick = (aux_phase == 0);
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
        tick_edge();
        bus_wr = 1'b0;
        if (a == 0) src_bus_tb = d[1];
    endtask

    task automatic rd(input int a, output int v);
        bus_rd = 1'b1; bus_addr = 2'(a);
        tick_edge();
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_rise(input string req, output int t);
        rose = 0;
        for (int i = 0; i < 6000 && !rose; i++) tick_edge();
        if (!rose) chk(0, req, 0, 1);
        t = rise_tick;
    endtask

    task automatic start(input int ctrl);
        wr(0, ctrl);
        ticks = 0;
        rose = 0;
    endtask

    task automatic measure(input bit bus, input int rate);
        int n, t0, t1;
        n = 2 * (rate + 1);
        wr(0, 4);
        wr(2, rate >> 8);
        wr(3, rate & 255);
        wr(1, 1);
        start(5 | (bus << 1));
        wait_rise(bus ? "R5" : "R6", t0);
        if (bus) chk(t0 == n + 1, "R5 first period", t0, n + 1);
        else     chk(t0 == n + 2, "R6 first period", t0, n + 2);
        for (int k = 0; k < 2; k++) begin
            wr(1, 1);
            wait_rise("R4", t1);
            chk(t1 - t0 == n, "R4 period", t1 - t0, n);
            t0 = t1;
        end
        wr(0, 4);
        wr(1, 1);
    endtask

    initial begin
        #(8 * 180000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, t;
        repeat (3) tick_edge();
        rst_n = 1'b1;
        tick_edge();

        // R1 reset values
        chk(irq_o == 0, "R1 irq", irq_o, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk(v == 0, "R1 reset reg", v, 0);
        end

        // R2 control readback, upper bits read zero
        wr(0, 8'hFE);
        rd(0, v);
        chk(v == 6, "R2 ctrl", v, 6);
        wr(2, 8'hA5); wr(3, 8'h3C);
        rd(2, v); chk(v == 8'hA5, "R2 rate hi", v, 8'hA5);
        rd(3, v); chk(v == 8'h3C, "R2 rate lo", v, 8'h3C);
        wr(0, 0);

        // R4 R5 R6 sweep over rates and both sources
        for (int i = 0; i < 9; i++) begin
            int r;
            r = (i < 7) ? i : ((i == 7) ? 37 : 258);
            measure(1'b1, r);
            measure(1'b0, r);
        end

        // R3 writes locked while running
        wr(2, 0); wr(3, 5);
        wr(1, 1);
        start(7);
        wr(2, 8'hAA); wr(3, 8'h55);
        rd(2, v); chk(v == 0, "R3 hi locked", v, 0);
        rd(3, v); chk(v == 5, "R3 lo locked", v, 5);
        wait_rise("R3", t);
        chk(t == 13, "R3 period unchanged", t, 13);
        wr(0, 4);
        wr(3, 9);
        rd(3, v); chk(v == 9, "R3 idle write", v, 9);

        // R7 flag sticky and write-one-to-clear
        rd(1, v); chk(v == 1, "R7 flag set", v, 1);
        wr(1, 0);
        rd(1, v); chk(v == 1, "R7 zero write ignored", v, 1);
        wr(1, 1);
        rd(1, v); chk(v == 0, "R7 cleared", v, 0);

        // R8 masked interrupt
        start(3);
        for (int i = 0; i < 30; i++) tick_edge();
        chk(irq_o == 0, "R8 masked", irq_o, 0);
        rd(1, v); chk(v == 1, "R8 flag still set", v, 1);
        wr(0, 7);
        chk(irq_o == 1, "R8 unmasked", irq_o, 1);
        wr(0, 4); wr(1, 1);

        // R9 stop and restart (rate 9, 20 ticks)
        start(7);
        for (int i = 0; i < 7; i++) tick_edge();
        wr(0, 6);
        for (int i = 0; i < 40; i++) tick_edge();
        rd(1, v); chk(v == 0, "R9 no timeout while stopped", v, 0);
        start(7);
        wait_rise("R9", t);
        chk(t == 21, "R9 full period after restart", t, 21);
        wr(0, 4); wr(1, 1);
        start(5);
        for (int i = 0; i < 10; i++) tick_edge();
        wr(0, 4);
        start(5);
        wait_rise("R9", t);
        chk(t == 22, "R9 aux full period after restart", t, 22);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule